// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Queue

This block sits between a processor data port and a simple next-level memory. It keeps 16 lines of four 32-bit words each, indexed directly by address bits, with one tag and one valid flag per line. Loads that hit return the stored word in the same cycle. Loads that miss stall the processor, wait for all queued stores to reach memory, and then fetch the whole line. The line is installed together with its tag, and the load then completes from the cache.

Stores never allocate a line. Every store is placed in a four-entry first-in first-out queue that drains to memory in the background, oldest entry first. A store that hits also rewrites the cached word on the same clock edge. A store that misses leaves the cache untouched. The processor is held only while a load miss is being served, or while it presents a store and the queue is full.

The processor holds its request (address, strobes, write data) until it sees `cpu_ready` high on a clock edge, and the operation completes on that edge. A read has priority if both strobes are high. With no request, `cpu_ready` is high while no miss is in progress.

Top module: `wtc_cache`

## Requirements
- R1: The address is decoded as tag = addr[31:8], line index = addr[7:4], word select = addr[3:2]. The byte bits addr[1:0] do not affect lookup, so a load to any byte of a cached word hits and returns that word.
- R2: After reset every line is invalid. The first load to any address is a miss, and with no request pending `cpu_ready` is 1 while `mem_rreq` and `mem_wreq` are 0.
- R3: A load that hits has `cpu_ready` high in the cycle it is presented and returns the cached word on `cpu_rdata`, with no line request to memory.
- R4: On a load miss, `mem_rreq` rises only after every earlier store has been accepted by memory. The address it carries is the line-aligned address (low 4 bits zero), and it is held stable until `mem_rack` is 1 on a clock edge.
- R5: After the request is accepted, the cache takes exactly four words, each on a cycle with `mem_rvalid` high, in word order 0 to 3. It installs them with the tag, sets the valid flag, and then completes the load. All four words of the line then hit.
- R6: Every accepted store produces exactly one memory write, in issue order. The write carries the store's full address on `mem_waddr` and its data on `mem_wdata`, and both are held stable until `mem_wack` is 1 on a clock edge.
- R7: A store that hits rewrites the cached word, so a later load to it hits and returns the new data.
- R8: A store that misses changes nothing in the cache. A line already held at that index still hits afterwards, and a load to the stored address then misses and returns the stored data from memory.
- R9: A store is accepted in the cycle it is presented while the queue holds fewer than 4 entries, and is held with `cpu_ready` low while the queue is full. A store may enter the queue on the same edge as the oldest entry leaves it.
- R10: A load miss to an index already holding another tag replaces that line, so a later load to the old line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Load request strobe |
| cpu_wr | input | 1 | Store request strobe |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_ready` is high for a load |
| cpu_ready | output | 1 | Request completes on this edge; low means stall |
| mem_rreq | output | 1 | Line fetch request |
| mem_raddr | output | 32 | Line-aligned fetch address |
| mem_rack | input | 1 | Memory accepts the line fetch |
| mem_rvalid | input | 1 | One fetched word is present on `mem_rdata` |
| mem_rdata | input | 32 | Fetched word |
| mem_wreq | output | 1 | Word write request from the store queue |
| mem_waddr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_wack | input | 1 | Memory accepts the write |

## Verification
Two functions can fall in the same cycle. A store can enter the queue on the very edge where memory takes the oldest queued store, and a store hit can rewrite a cached word while an older store to the same word is still draining. The bench provokes both with a memory model whose write acceptance is random on every cycle, mixed with random loads and stores over a small address range that makes indexes collide often. Each memory write is judged against a bench queue of expected stores in issue order, each load against a shadow of program-order data, and each hit or miss against a bench tag model. A directed run holds write acceptance off to fill the queue and confirm the stall on the fifth store.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_REQ   = 2'd2,
      ST_FILL  = 2'd3
   } wtc_state_e;

endpackage

// File: rtl/wtc_store_q.sv
module wtc_store_q #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic          empty,
   output logic          mem_wreq,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_wack
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_chk_depth
      $error("wtc_store_q: DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          pop;

   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign mem_wreq  = !empty;
   assign mem_waddr = addr_q[rp_q];
   assign mem_wdata = data_q[rp_q];
   assign pop       = mem_wreq && mem_wack;

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wp_q] <= push_addr;
         data_q[wp_q] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + PW'(1);
         if (pop)  rp_q <= rp_q + PW'(1);
         unique case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R9: the controller never pushes into a full queue
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R6: a pending write keeps its address and data until accepted
   a_r6_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wreq && !mem_wack) |=> (mem_wreq && $stable(mem_waddr) && $stable(mem_wdata)));

endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
   parameter int IDXW = 4,
   parameter int WSW  = 2,
   parameter int TAGW = 24,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] lk_idx,
   input  logic [WSW-1:0]  lk_word,
   input  logic [TAGW-1:0] lk_tag,
   output logic            lk_hit,
   output logic [DW-1:0]   lk_data,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [WSW-1:0]  wr_word,
   input  logic [DW-1:0]   wr_data,
   input  logic            inst_en,
   input  logic [IDXW-1:0] inst_idx,
   input  logic [TAGW-1:0] inst_tag
);
   localparam int NLINES = 1 << IDXW;
   localparam int NWORDS = NLINES << WSW;

   logic [DW-1:0]   data_q [NWORDS];
   logic [TAGW-1:0] tag_q  [NLINES];
   logic [NLINES-1:0] valid_q;

   for (genvar g = 0; g < NLINES; g++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_q[g] <= 1'b0;
         else if (inst_en && inst_idx == IDXW'(g))
            valid_q[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (inst_en) tag_q[inst_idx] <= inst_tag;
      if (wr_en)   data_q[{wr_idx, wr_word}] <= wr_data;
   end

   assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = data_q[{lk_idx, lk_word}];

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int IDXW  = 4,
   parameter int WSW   = 2,
   parameter int QDEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_ready,
   output logic          mem_rreq,
   output logic [AW-1:0] mem_raddr,
   input  logic          mem_rack,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_wreq,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_wack
);
   import wtc_pkg::*;

   localparam int BOFF = 2;
   localparam int LOW  = BOFF + WSW;
   localparam int TAGW = AW - IDXW - LOW;
   localparam logic [WSW-1:0] LAST_W = '1;

   if (TAGW < 1) begin : g_chk_split
      $error("wtc_cache: address too narrow for index and word select");
   end
   if (DW != 32) begin : g_chk_word
      $error("wtc_cache: word width must be 32 for a 2-bit byte offset");
   end

   logic [IDXW-1:0] a_idx;
   logic [WSW-1:0]  a_word;
   logic [TAGW-1:0] a_tag;

   assign a_idx  = cpu_addr[LOW +: IDXW];
   assign a_word = cpu_addr[BOFF +: WSW];
   assign a_tag  = cpu_addr[AW-1 -: TAGW];

   wtc_state_e      st_q;
   logic [WSW-1:0]  fill_q;
   logic [IDXW-1:0] miss_idx_q;
   logic [TAGW-1:0] miss_tag_q;

   logic hit, q_full, q_empty, idle, st_go, fill_we, inst_en;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [WSW-1:0]  wr_word;
   logic [DW-1:0]   wr_data;

   assign idle    = (st_q == ST_IDLE);
   assign st_go   = idle && cpu_wr && !cpu_rd && !q_full;
   assign fill_we = (st_q == ST_FILL) && mem_rvalid;
   assign inst_en = fill_we && (fill_q == LAST_W);

   always_comb begin
      if (cpu_rd)      cpu_ready = idle && hit;
      else if (cpu_wr) cpu_ready = idle && !q_full;
      else             cpu_ready = idle;
   end

   always_comb begin
      if (fill_we) begin
         wr_en   = 1'b1;
         wr_idx  = miss_idx_q;
         wr_word = fill_q;
         wr_data = mem_rdata;
      end else begin
         wr_en   = st_go && hit;
         wr_idx  = a_idx;
         wr_word = a_word;
         wr_data = cpu_wdata;
      end
   end

   assign mem_rreq  = (st_q == ST_REQ);
   assign mem_raddr = {miss_tag_q, miss_idx_q, {LOW{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         fill_q     <= '0;
         miss_idx_q <= '0;
         miss_tag_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cpu_rd && !hit) begin
               st_q       <= ST_DRAIN;
               miss_idx_q <= a_idx;
               miss_tag_q <= a_tag;
            end
            ST_DRAIN: if (q_empty) st_q <= ST_REQ;
            ST_REQ: if (mem_rack) begin
               st_q   <= ST_FILL;
               fill_q <= '0;
            end
            ST_FILL: if (mem_rvalid) begin
               fill_q <= fill_q + WSW'(1);
               if (fill_q == LAST_W) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   wtc_lines #(.IDXW(IDXW), .WSW(WSW), .TAGW(TAGW), .DW(DW)) i_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (a_idx),
      .lk_word  (a_word),
      .lk_tag   (a_tag),
      .lk_hit   (hit),
      .lk_data  (cpu_rdata),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_word  (wr_word),
      .wr_data  (wr_data),
      .inst_en  (inst_en),
      .inst_idx (miss_idx_q),
      .inst_tag (miss_tag_q)
   );

   wtc_store_q #(.AW(AW), .DW(DW), .DEPTH(QDEPTH)) i_store_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (st_go),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .full      (q_full),
      .empty     (q_empty),
      .mem_wreq  (mem_wreq),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .mem_wack  (mem_wack)
   );

   // R4: a line fetch is only issued once the store queue has drained
   a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rreq |-> !mem_wreq);

   // R4: the fetch request and its address hold until accepted
   a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rreq && !mem_rack) |=> (mem_rreq && $stable(mem_raddr)));

   // R3: a completing load never coincides with a fetch in progress
   a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_ready) |-> !mem_rreq);

endmodule

// File: tb/test_wtc_cache.sv
module test_wtc_cache;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = CLK_PERIOD / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic cpu_ready;
   logic mem_rreq;
   logic [31:0] mem_raddr;
   logic mem_rack = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic mem_wreq;
   logic [31:0] mem_waddr, mem_wdata;
   logic mem_wack = 1'b0;

   always #(HALF) clk = ~clk;

   wtc_cache i_wtc_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_rreq(mem_rreq), .mem_raddr(mem_raddr), .mem_rack(mem_rack),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_wreq(mem_wreq), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wack(mem_wack)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] bmem   [256];
   logic [31:0] shadow [256];
   logic [31:0] qa [1024];
   logic [31:0] qd [1024];
   int qh = 0, qt = 0;
   int rreq_cnt = 0;
   bit fill_on = 1'b0;
   int fill_base = 0, fill_k = 0;
   bit hold_w = 1'b0;
   bit exp_v [16];
   logic [23:0] exp_t [16];

   function automatic logic [31:0] init_word(int i);
      return 32'(i) * 32'h9E37_79B1 + 32'h0000_5A5A;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory-side monitor: samples values present just before each edge
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_wreq && mem_wack) begin
            if (qh == qt) begin
               chk(1'b0, "R6", "write with no store pending", mem_waddr, 32'h0);
            end else begin
               chk(mem_waddr == qa[qh] && mem_wdata == qd[qh], "R6", "write order/addr",
                   mem_waddr ^ mem_wdata, qa[qh] ^ qd[qh]);
               bmem[mem_waddr[9:2]] = mem_wdata;
               qh++;
            end
         end
         if (mem_rreq && mem_rack) begin
            chk(qh == qt, "R4", "stores pending at fetch", 32'(qt - qh), 32'h0);
            chk(mem_raddr[3:0] == 4'h0, "R4", "fetch address alignment", mem_raddr, {mem_raddr[31:4], 4'h0});
            rreq_cnt++;
            fill_on = 1'b1;
            fill_base = int'(mem_raddr[9:2]);
            fill_k = 0;
         end else if (fill_on && mem_rvalid) begin
            fill_k++;
            if (fill_k == 4) fill_on = 1'b0;
         end
      end
   end

   // memory-side responder: drives on falling edges
   initial begin
      forever begin
         @(negedge clk);
         mem_wack = !hold_w && ($urandom % 3 != 0);
         mem_rack = ($urandom % 2 == 0);
         if (fill_on && ($urandom % 4 != 0)) begin
            mem_rvalid = 1'b1;
            mem_rdata  = bmem[(fill_base + fill_k) % 256];
         end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
         end
      end
   end

   task automatic cpu_op(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] q, output int waits);
      @(negedge clk);
      cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      waits = 0;
      forever begin
         #(HALF - 1);
         if (cpu_ready) begin
            q = cpu_rdata;
            break;
         end
         waits++;
         @(negedge clk);
      end
      if (wr) begin
         qa[qt % 1024] = a; qd[qt % 1024] = d; qt++;
         shadow[a[9:2]] = d;
      end
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [31:0] a, input string req);
      logic [31:0] q;
      int w, c0;
      bit exp_miss;
      exp_miss = !exp_v[a[7:4]] || exp_t[a[7:4]] != a[31:8];
      c0 = rreq_cnt;
      cpu_op(1'b0, a, 32'h0, q, w);
      exp_v[a[7:4]] = 1'b1;
      exp_t[a[7:4]] = a[31:8];
      chk(q == shadow[a[9:2]], req, "load data", q, shadow[a[9:2]]);
      chk((rreq_cnt != c0) == exp_miss, req, "miss expectation", 32'(rreq_cnt - c0), 32'(exp_miss));
      if (!exp_miss) chk(w == 0, req, "hit stall cycles", 32'(w), 32'h0);
   endtask

   task automatic st(input logic [31:0] a, input logic [31:0] d, output int w);
      logic [31:0] q;
      cpu_op(1'b1, a, d, q, w);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w, w5;
      logic [31:0] a;
      process::self().srandom(32'd1234);
      for (int i = 0; i < 256; i++) begin
         bmem[i] = init_word(i);
         shadow[i] = init_word(i);
      end
      for (int i = 0; i < 16; i++) begin
         exp_v[i] = 1'b0;
         exp_t[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(cpu_ready == 1'b1, "R2", "ready after reset", 32'(cpu_ready), 32'h1);
      chk(mem_rreq == 1'b0, "R2", "fetch after reset", 32'(mem_rreq), 32'h0);
      chk(mem_wreq == 1'b0, "R2", "write after reset", 32'(mem_wreq), 32'h0);

      rd_chk(32'h0000_0010, "R2");
      rd_chk(32'h0000_0014, "R5");
      rd_chk(32'h0000_0018, "R5");
      rd_chk(32'h0000_001C, "R5");
      rd_chk(32'h0000_0013, "R1");
      rd_chk(32'h0000_0016, "R1");

      st(32'h0000_0014, 32'hCAFE_0001, w);
      rd_chk(32'h0000_0014, "R7");
      st(32'h0000_0118, 32'hBEEF_0002, w);
      rd_chk(32'h0000_0018, "R8");
      rd_chk(32'h0000_0118, "R8");
      rd_chk(32'h0000_0014, "R10");
      rd_chk(32'h0000_0114, "R10");

      // R9: fill the queue with memory writes held off
      @(posedge clk); #1 hold_w = 1'b1;
      repeat (2) @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         st(32'h0000_0200 + 32'(i * 4), 32'h1111_0000 + 32'(i), w);
         chk(w == 0, "R9", "store stalled below full", 32'(w), 32'h0);
      end
      fork
         st(32'h0000_0220, 32'h1111_0005, w5);
         begin
            repeat (5) @(posedge clk);
            #1 hold_w = 1'b0;
         end
      join
      chk(w5 >= 3, "R9", "store not stalled when full", 32'(w5), 32'h3);

      // random mix (R3, R6, R7, R8, R10 under random acceptance)
      for (int n = 0; n < 600; n++) begin
         a = {22'h0, 8'($urandom), 2'b00};
         if ($urandom % 2 == 0) begin
            rd_chk(a | 32'($urandom % 4), "R3");
         end else begin
            st(a, $urandom, w);
         end
      end

      for (int t = 0; t < 2000 && qh != qt; t++) @(negedge clk);
      chk(qh == qt, "R6", "stores left undrained", 32'(qt - qh), 32'h0);
      for (int i = 0; i < 256; i++) begin
         if (bmem[i] != shadow[i])
            chk(1'b0, "R6", "memory image", bmem[i], shadow[i]);
      end
      chk(1'b1, "R6", "memory image complete", 32'h0, 32'h0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule